// File: doc/BRIEF.md
# Configuration Image Checksum Checker

This block validates a 64-byte configuration image while it streams past, one byte per accepted cycle, each byte tagged with its own address. It runs two independent integrity checks in parallel. The station-address check adds up the sixteen bytes of the address window at 16-bit width. That sum leaves out the two bytes that hold the stored checksum, and it is then compared with those two bytes. The whole-image check adds all 64 bytes modulo 256 and expects the result to be FFh. The final byte of the image is an adjust value picked so that this total comes out right.

A start pulse clears the checker before each image. The source may present bytes in any address order. Every address must arrive exactly once. A repeated address or an address still missing when the final address comes in raises a sticky sequence error, and that error blocks both pass flags. When the byte at the final address is accepted, the block reports done together with the two pass flags and holds them until the next start.

Top module: `cfg_image_checker`

## Requirements
- R1: After reset, and in the cycle after a start pulse, done_o, seq_err_o, addr_ok_o and image_ok_o are all 0.
- R2: addr_ok_o is 1 while done_o is 1 only if the 16-bit sum, carries kept, of the bytes at addresses 00h-0Bh, 0Eh and 0Fh equals the stored value {byte 0Dh, byte 0Ch}, with 0Ch the low byte. seq_err_o must also be 0.
- R3: The bytes at 0Ch and 0Dh do not enter the station-address sum. Changing either of them changes only the stored value.
- R4: image_ok_o is 1 while done_o is 1 only if the 8-bit sum of all 64 bytes, with 0Ch, 0Dh and 3Fh included, equals FFh. seq_err_o must also be 0.
- R5: done_o rises at the clock edge that accepts the byte at address 3Fh, so it is high in the cycle after that acceptance cycle. It stays high until a start pulse.
- R6: Bytes may arrive in any address order. The results do not depend on the order.
- R7: Accepting an address that was already accepted since the last start sets seq_err_o from the next cycle on. The flag stays set until a start pulse.
- R8: If any address is still missing when the byte at 3Fh is accepted, seq_err_o is 1 together with done_o.
- R9: A byte offered while done_o is 1, or in the same cycle as start_i, is ignored.
- R10: addr_ok_o and image_ok_o are 0 whenever done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the checker for a new image |
| byte_valid_i | input | 1 | A byte is offered this cycle |
| byte_addr_i | input | 6 | Address of the offered byte |
| byte_data_i | input | 8 | Value of the offered byte |
| done_o | output | 1 | The byte at the last address has been accepted |
| addr_ok_o | output | 1 | Station-address checksum passed |
| image_ok_o | output | 1 | Whole-image checksum passed |
| seq_err_o | output | 1 | An address was repeated or missing |

## Verification
Every result is registered once. done_o, both pass flags and a missing-address error appear directly after the edge that takes in byte 3Fh. A duplicate error appears directly after the edge that takes in the repeated byte. The bench drives each byte half a cycle before its edge and reads outputs one time unit after that edge. It also samples done_o just before the final edge to show that done_o is not yet high at that point. Ignored bytes are checked by sampling again after the edge they were offered on.

// File: rtl/cfg_ck_pkg.sv
package cfg_ck_pkg;
   localparam int BYTE_W = 8;

   // True when address a lies in the inclusive window [lo, hi].
   function automatic logic in_span(input int unsigned a,
                                    input int unsigned lo,
                                    input int unsigned hi);
      return (a >= lo) && (a <= hi);
   endfunction

   // Station sum membership: inside the station window but not a stored checksum byte.
   function automatic logic in_station(input int unsigned a,
                                       input int unsigned sta_end,
                                       input int unsigned ck_addr,
                                       input int unsigned ck_bytes);
      return in_span(a, 0, sta_end) && !in_span(a, ck_addr, ck_addr + ck_bytes - 1);
   endfunction
endpackage

// File: rtl/ck_addr_tracker.sv
module ck_addr_tracker #(
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              last_i,
   output logic              err_o
);
   logic [DEPTH-1:0] seen_q;
   logic [DEPTH-1:0] hit;
   logic             err_q;
   logic             dup;
   logic             gap;

   always_comb begin
      hit         = '0;
      hit[addr_i] = 1'b1;
   end

   assign dup = accept_i && seen_q[addr_i];
   assign gap = accept_i && last_i && !(&(seen_q | hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         err_q  <= 1'b0;
      end else if (clear_i) begin
         seen_q <= '0;
         err_q  <= 1'b0;
      end else begin
         if (accept_i) seen_q <= seen_q | hit;
         if (dup || gap) err_q <= 1'b1;
      end
   end

   assign err_o = err_q;
endmodule

// File: rtl/ck_station_sum.sv
module ck_station_sum
   import cfg_ck_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int SUM_W    = 16,
   parameter int CK_ADDR  = 12,
   parameter int STA_END  = 15,
   localparam int CK_BYTES = SUM_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              match_o
);
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] stored_q;
   logic             member;

   assign member = in_station(int'(addr_i), STA_END, CK_ADDR, CK_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sum_q <= '0;
      else if (clear_i)            sum_q <= '0;
      else if (accept_i && member) sum_q <= sum_q + SUM_W'(data_i);
   end

   // One capture lane per stored checksum byte, lowest address is least significant.
   for (genvar g = 0; g < CK_BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stored_q[g*BYTE_W +: BYTE_W] <= '0;
         else if (clear_i)
            stored_q[g*BYTE_W +: BYTE_W] <= '0;
         else if (accept_i && (addr_i == ADDR_W'(CK_ADDR + g)))
            stored_q[g*BYTE_W +: BYTE_W] <= data_i;
      end
   end

   assign match_o = (sum_q == stored_q);
endmodule

// File: rtl/ck_image_sum.sv
module ck_image_sum
   import cfg_ck_pkg::*;
#(
   parameter int               ADDR_W = 6,
   parameter logic [BYTE_W-1:0] TARGET = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              accept_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              match_o
);
   logic [BYTE_W-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sum_q <= '0;
      else if (clear_i)  sum_q <= '0;
      else if (accept_i) sum_q <= sum_q + data_i;
   end

   assign match_o = (sum_q == TARGET);
endmodule

// File: rtl/cfg_image_checker.sv
module cfg_image_checker
   import cfg_ck_pkg::*;
#(
   parameter int               DEPTH   = 64,
   parameter int               SUM_W   = 16,
   parameter int               CK_ADDR = 12,
   parameter int               STA_END = 15,
   parameter logic [BYTE_W-1:0] TARGET  = 8'hFF,
   localparam int              ADDR_W  = $clog2(DEPTH),
   localparam int              LAST    = DEPTH - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_valid_i,
   input  logic [ADDR_W-1:0] byte_addr_i,
   input  logic [BYTE_W-1:0] byte_data_i,
   output logic              done_o,
   output logic              addr_ok_o,
   output logic              image_ok_o,
   output logic              seq_err_o
);
   initial begin
      if (DEPTH != (1 << ADDR_W)) $error("DEPTH must be a power of two");
      if (SUM_W % BYTE_W != 0)    $error("SUM_W must be whole bytes");
      if (CK_ADDR + SUM_W / BYTE_W - 1 > STA_END) $error("checksum bytes outside window");
      if (STA_END >= LAST)        $error("station window overlaps last address");
   end

   logic done_q;
   logic accept;
   logic is_last;
   logic sta_match;
   logic img_match;
   logic err;

   assign accept  = byte_valid_i && !start_i && !done_q;
   assign is_last = (byte_addr_i == ADDR_W'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  done_q <= 1'b0;
      else if (start_i)            done_q <= 1'b0;
      else if (accept && is_last)  done_q <= 1'b1;
   end

   ck_addr_tracker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
      .addr_i(byte_addr_i), .last_i(is_last), .err_o(err)
   );

   ck_station_sum #(.ADDR_W(ADDR_W), .SUM_W(SUM_W), .CK_ADDR(CK_ADDR),
                    .STA_END(STA_END)) u_sta (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
      .addr_i(byte_addr_i), .data_i(byte_data_i), .match_o(sta_match)
   );

   ck_image_sum #(.ADDR_W(ADDR_W), .TARGET(TARGET)) u_img (
      .clk(clk), .rst_n(rst_n), .clear_i(start_i), .accept_i(accept),
      .data_i(byte_data_i), .match_o(img_match)
   );

   assign done_o     = done_q;
   assign seq_err_o  = err;
   assign addr_ok_o  = done_q && !err && sta_match;
   assign image_ok_o = done_q && !err && img_match;
endmodule

module cfg_image_checker_sva #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              byte_valid_i,
   input logic [ADDR_W-1:0] byte_addr_i,
   input logic              done_o,
   input logic              addr_ok_o,
   input logic              image_ok_o,
   input logic              seq_err_o
);
   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !seq_err_o && !addr_ok_o && !image_ok_o));

   p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !start_i && !done_o && (&byte_addr_i)) |=> done_o);

   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_err_o && !start_i) |=> seq_err_o);

   p_err_blocks_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err_o |-> (!addr_ok_o && !image_ok_o));

   p_ignore_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> ($stable(addr_ok_o) && $stable(image_ok_o) && $stable(seq_err_o)));

   p_flags_need_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!addr_ok_o && !image_ok_o));
endmodule

bind cfg_image_checker cfg_image_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
   .byte_addr_i(byte_addr_i), .done_o(done_o), .addr_ok_o(addr_ok_o),
   .image_ok_o(image_ok_o), .seq_err_o(seq_err_o)
);

// File: tb/cfg_image_checker_tb.sv
module cfg_image_checker_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       byte_valid_i = 1'b0;
   logic [5:0] byte_addr_i = '0;
   logic [7:0] byte_data_i = '0;
   logic       done_o, addr_ok_o, image_ok_o, seq_err_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] img [64];

   always #4 clk = ~clk;

   cfg_image_checker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
      .byte_addr_i(byte_addr_i), .byte_data_i(byte_data_i), .done_o(done_o),
      .addr_ok_o(addr_ok_o), .image_ok_o(image_ok_o), .seq_err_o(seq_err_o)
   );

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {done,addr_ok,image_ok,seq_err} actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [3:0] outs();
      return {done_o, addr_ok_o, image_ok_o, seq_err_o};
   endfunction

   function automatic logic station_in(input int a);
      return (a <= 15) && (a != 12) && (a != 13);
   endfunction

   function automatic logic [15:0] station_sum();
      logic [15:0] s = '0;
      for (int a = 0; a < 16; a++) if (station_in(a)) s += 16'(img[a]);
      return s;
   endfunction

   function automatic logic exp_sta();
      return station_sum() == {img[13], img[12]};
   endfunction

   function automatic logic exp_img();
      logic [7:0] s = '0;
      for (int a = 0; a < 64; a++) s += img[a];
      return s == 8'hFF;
   endfunction

   task automatic build(input int k);
      logic [7:0] s = '0;
      logic [15:0] st;
      for (int a = 0; a < 64; a++) img[a] = 8'((a * 37 + k * 11 + 5) ^ (k * 3));
      st = station_sum();
      img[12] = st[7:0];
      img[13] = st[15:8];
      for (int a = 0; a < 63; a++) s += img[a];
      img[63] = 8'hFF - s;
   endtask

   task automatic do_start();
      @(negedge clk);
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
   endtask

   task automatic send(input int a);
      @(negedge clk);
      byte_valid_i = 1'b1;
      byte_addr_i  = 6'(a);
      byte_data_i  = img[a];
      @(posedge clk); #1;
      byte_valid_i = 1'b0;
   endtask

   // Sends addresses (i*stride)%63 for i=0..62, then 3Fh; skip<0 and dup<0 disable.
   task automatic feed(input int stride, input int skip, input int dup, input string req);
      for (int i = 0; i < 63; i++) begin
         int a = (i * stride) % 63;
         if (a != skip) send(a);
         if (a == dup) begin
            send(a);
            chk({req, " dup flagged next cycle R7"}, {1'b0, outs()[2:0] & 3'b001}, 4'b0001);
         end
      end
      chk({req, " before last edge R5"}, {done_o, 3'b000}, 4'b0000);
      send(63);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("reset R1", outs(), 4'b0000);
      rst_n = 1'b1;

      // Valid images in several orders and data patterns.
      for (int k = 0; k < 12; k++) begin
         int strides[4] = '{1, 5, 2, 62};
         build(k);
         do_start();
         chk("after start R1", outs(), 4'b0000);
         feed(strides[k % 4], -1, -1, "valid");
         chk("valid image R2 R4 R5 R6", outs(), 4'b1110);
      end

      // Carry in the station sum: every station byte FFh.
      build(3);
      for (int a = 0; a < 16; a++) if (station_in(a)) img[a] = 8'hFF;
      img[12] = 8'hF2; img[13] = 8'h0D;
      begin
         logic [7:0] s = '0;
         for (int a = 0; a < 63; a++) s += img[a];
         img[63] = 8'hFF - s;
      end
      do_start();
      feed(1, -1, -1, "carry");
      chk("16-bit carries kept R2", outs(), {1'b1, exp_sta(), exp_img(), 1'b0});

      // Single-byte corruption sweep over every address.
      for (int a = 0; a < 64; a++) begin
         build(a + 20);
         img[a] = img[a] ^ 8'h41;
         do_start();
         feed(1, -1, -1, "corrupt");
         chk((station_in(a) || a == 12 || a == 13) ? "corrupt station/stored R2 R3"
                                                    : "corrupt other byte R3 R4",
             outs(), {1'b1, exp_sta(), 1'b0, 1'b0});
      end

      // Bad stored checksum but adjust byte fixed: only station check fails.
      build(40);
      img[12] = img[12] + 8'd1;
      img[63] = img[63] - 8'd1;
      do_start();
      feed(5, -1, -1, "badstored");
      chk("bad stored value R2 R3", outs(), 4'b1010);

      // Duplicate address.
      build(41);
      do_start();
      feed(1, -1, 5, "dup");
      chk("duplicate blocks pass R7", outs(), 4'b1001);

      // Missing address.
      build(42);
      do_start();
      feed(1, 7, -1, "missing");
      chk("missing address R8", outs(), 4'b1001);

      // Bytes after done are ignored.
      build(43);
      do_start();
      feed(1, -1, -1, "post");
      begin
         logic [7:0] keep = img[0];
         img[0] = keep + 8'd9;
         send(0);
         send(63);
         img[0] = keep;
      end
      chk("bytes after done ignored R9", outs(), 4'b1110);

      // A byte in the start cycle is ignored.
      build(44);
      @(negedge clk);
      start_i = 1'b1;
      byte_valid_i = 1'b1;
      byte_addr_i = 6'd63;
      byte_data_i = img[63];
      @(posedge clk); #1;
      start_i = 1'b0;
      byte_valid_i = 1'b0;
      chk("byte with start ignored R9", outs(), 4'b0000);
      for (int a = 0; a < 30; a++) send(a);
      chk("flags low mid-image R10", outs(), 4'b0000);
      for (int a = 30; a < 64; a++) send(a);
      chk("image after start-cycle byte R9", outs(), 4'b1110);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R5: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule